// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an on-chip ring memory. While capture is enabled, every word presented with its valid strobe passes through a short register pipeline and is then written at the write pointer, which advances and wraps over the oldest data. A trigger input arms a post-trigger countdown. Once the programmed number of further words has been stored, acquisition is marked complete and capture stops by itself.

Software reaches the block through a simple register port with single-cycle write and read strobes, a 4-bit address and read data one cycle later. To unload the buffer it reads the status and the write pointer, places the read pointer at the oldest frame, and reads the data register repeatedly. Each data read returns the next frame. If nothing has wrapped, frames 0 up to write pointer minus 1 are valid. After a wrap, the oldest frame is at the write pointer.

Top module: `trace_ring_buffer`

## Requirements
- R1: Register addresses are 0 identification (reads the ID_VALUE parameter), 1 depth (reads DEPTH), 2 width (reads 32), 3 status, 4 data, 5 read pointer, 6 write pointer, 7 trigger count, 8 control. After reset, status reads 8 (pipeline empty only), and control, both pointers and the trigger count read 0.
- R2: When control bit 0 is set, acquisition is not complete, and the countdown has not run out, each trace word with `trc_valid` high is stored at the write pointer. The pointer then advances by one modulo DEPTH, and words are stored in arrival order.
- R3: Status bit 0 (wrapped) sets when a store moves the write pointer from DEPTH-1 to 0. It stays set until software writes the write-pointer register, and that write clears it.
- R4: Status bit 1 (triggered) sets only when `trc_trigger` is high while control bit 0 is set. A control write with bit 0 set clears status bits 1 and 2.
- R5: After the trigger cycle, exactly the programmed trigger count of further words is stored. Status bit 2 (complete) then sets, control bit 0 reads 0, and further words are not stored. With a count of 0, no word after the trigger cycle is stored.
- R6: Status bit 3 is low while any accepted word is still in the two-stage pipeline before the memory. It is high once every accepted word has been written.
- R7: A read of the data register returns, one cycle later on `reg_rdata`, the frame at the read pointer. It also advances the read pointer by one modulo DEPTH, so two consecutive data reads return two consecutive frames.
- R8: The read pointer and write pointer can be written by software and read back. The trigger count can also be written by software and read back.
- R9: Control bits 1:0 read back as written, where bit 1 is the demultiplexed-input mode flag. Writing 0 to control stops further words being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | Trace word strobe |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that software does not rewrite the write pointer while words are still draining from the pipeline. The stimulus keeps to these rules because register accesses are issued one at a time, only after idle trace cycles. Random trace bursts with gaps in the valid strobe then run against a bench model of the ring. Directed cases target the wrap boundary, a zero countdown, and a trigger while capture is disabled.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [3:0] {
    RA_IDENT  = 4'd0,
    RA_DEPTH  = 4'd1,
    RA_WIDTH  = 4'd2,
    RA_STATUS = 4'd3,
    RA_DATA   = 4'd4,
    RA_RPTR   = 4'd5,
    RA_WPTR   = 4'd6,
    RA_TCOUNT = 4'd7,
    RA_CTRL   = 4'd8
  } trc_reg_e;

  localparam int STAT_WRAP  = 0;
  localparam int STAT_TRIG  = 1;
  localparam int STAT_DONE  = 2;
  localparam int STAT_EMPTY = 3;
endpackage

// File: rtl/trc_pipe.sv
module trc_pipe #(
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          empty
);
  logic [STAGES-1:0] vld;
  logic [DW-1:0]     dat [STAGES];

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= in_valid;
    dat[0] <= in_data;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld[s] <= 1'b0;
        else     vld[s] <= vld[s-1];
        dat[s] <= dat[s-1];
      end
    end
  endgenerate

  assign out_valid = vld[STAGES-1];
  assign out_data  = dat[STAGES-1];
  assign empty     = (vld == '0);
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
  import trc_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          STAGES   = 2,
  parameter logic [31:0] ID_VALUE = 32'h7C0B_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trigger,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int DW = 32;
  localparam int AW = $clog2(DEPTH);

  logic          en, demux, trig_f, done_f, full_f;
  logic [AW-1:0] wp, rp;
  logic [31:0]   cnt;
  logic          halt, accept;
  logic          pv, empty;
  logic [DW-1:0] pd, ram_q;
  logic          rd_data, rsel_q;
  logic [31:0]   rval_q, status;

  logic wr_wp, wr_rp, wr_cnt, wr_ctl;
  assign wr_wp  = reg_wr && (reg_addr == RA_WPTR);
  assign wr_rp  = reg_wr && (reg_addr == RA_RPTR);
  assign wr_cnt = reg_wr && (reg_addr == RA_TCOUNT);
  assign wr_ctl = reg_wr && (reg_addr == RA_CTRL);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);

  // countdown exhausted after trigger: no more words enter
  assign halt   = trig_f && (cnt == 32'd0);
  assign accept = en && trc_valid && !done_f && !halt;

  trc_pipe #(.DW(DW), .STAGES(STAGES)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (accept),
    .in_data  (trc_data),
    .out_valid(pv),
    .out_data (pd),
    .empty    (empty)
  );

  trc_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (pv),
    .waddr(wp),
    .wdata(pd),
    .re   (rd_data),
    .raddr(rp),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      full_f <= 1'b0;
    end else if (wr_wp) begin
      wp     <= reg_wdata[AW-1:0];
      full_f <= 1'b0;
    end else if (pv) begin
      wp <= wp + AW'(1);
      if (wp == AW'(DEPTH - 1)) full_f <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rp <= '0;
    else if (wr_rp)   rp <= reg_wdata[AW-1:0];
    else if (rd_data) rp <= rp + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (wr_cnt)           cnt <= reg_wdata;
    else if (accept && trig_f) cnt <= cnt - 32'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      demux  <= 1'b0;
      trig_f <= 1'b0;
      done_f <= 1'b0;
    end else if (wr_ctl) begin
      en    <= reg_wdata[0];
      demux <= reg_wdata[1];
      if (reg_wdata[0]) begin
        trig_f <= 1'b0;
        done_f <= 1'b0;
      end
    end else begin
      if (en && trc_trigger) trig_f <= 1'b1;
      if (halt && !done_f) begin
        done_f <= 1'b1;
        en     <= 1'b0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[STAT_WRAP]  = full_f;
    status[STAT_TRIG]  = trig_f;
    status[STAT_DONE]  = done_f;
    status[STAT_EMPTY] = empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= 1'b0;
      rval_q <= '0;
    end else begin
      rsel_q <= rd_data;
      if (reg_rd) begin
        case (reg_addr)
          RA_IDENT:  rval_q <= ID_VALUE;
          RA_DEPTH:  rval_q <= 32'(DEPTH);
          RA_WIDTH:  rval_q <= 32'(DW);
          RA_STATUS: rval_q <= status;
          RA_RPTR:   rval_q <= 32'(rp);
          RA_WPTR:   rval_q <= 32'(wp);
          RA_TCOUNT: rval_q <= cnt;
          RA_CTRL:   rval_q <= {30'd0, demux, en};
          default:   rval_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rsel_q ? 32'(ram_q) : rval_q;
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int AW     = 6,
  parameter int STAGES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [3:0]    reg_addr,
  input logic          trc_trigger,
  input logic          en,
  input logic          trig_f,
  input logic          done_f,
  input logic          full_f,
  input logic          empty,
  input logic [AW-1:0] rp
);
  logic [7:0] done_run;

  always_ff @(posedge clk) begin
    if (rst || !done_f) done_run <= '0;
    else if (done_run != 8'hFF) done_run <= done_run + 8'd1;
  end

  AST_RDPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 4'd4) |=> rp == $past(rp) + AW'(1)); // R7

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full_f && !(reg_wr && reg_addr == 4'd6)) |=> full_f); // R3

  AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_f) |-> $past(en && trc_trigger)); // R4

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    $rose(done_f) |-> !en); // R5

  AST_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (done_run >= 8'(STAGES)) |-> empty); // R6
endmodule

bind trace_ring_buffer trc_checker #(.AW(AW), .STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .trc_trigger(trc_trigger),
  .en         (en),
  .trig_f     (trig_f),
  .done_f     (done_f),
  .full_f     (full_f),
  .empty      (empty),
  .rp         (rp)
);

// File: tb/sim_trace_ring_buffer.sv
`timescale 1ns/1ps
module sim_trace_ring_buffer;
  localparam int DEPTH = 64;
  localparam logic [31:0] IDV = 32'h7C0B_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trc_valid = 1'b0, trc_trigger = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] trc_data = '0, reg_wdata = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;

  // bench model
  logic [31:0] mem_m [DEPTH];
  int wp_m = 0, rp_m = 0;
  logic [31:0] cnt_m = 0;
  bit en_m = 0, dm_m = 0, trig_m = 0, done_m = 0, full_m = 0;

  always #5 clk = ~clk;

  trace_ring_buffer #(.DEPTH(DEPTH), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_trigger(trc_trigger), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] status_m(bit emp);
    return {28'd0, emp, done_m, trig_m, full_m};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one trace cycle of the model, using state from before the edge
  task automatic tick(bit v, logic [31:0] d, bit t);
    bit halt = trig_m && (cnt_m == 0);
    bit acc = en_m && v && !done_m && !halt;
    bit old_trig = trig_m;
    if (acc) begin
      mem_m[wp_m] = d;
      if (wp_m == DEPTH - 1) full_m = 1;
      wp_m = (wp_m + 1) % DEPTH;
      if (old_trig) cnt_m = cnt_m - 1;
    end
    if (en_m && t) trig_m = 1;
    if (halt && !done_m) begin done_m = 1; en_m = 0; end
  endtask

  task automatic step(bit v, logic [31:0] d, bit t);
    trc_valid = v; trc_data = d; trc_trigger = t;
    tick(v, d, t);
    @(negedge clk);
    trc_valid = 0; trc_trigger = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a != 4'd8) tick(0, '0, 0);
    case (a)
      4'd5: rp_m = int'(d) % DEPTH;
      4'd6: begin wp_m = int'(d) % DEPTH; full_m = 0; end
      4'd7: cnt_m = d;
      4'd8: begin en_m = d[0]; dm_m = d[1]; if (d[0]) begin trig_m = 0; done_m = 0; end end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] q);
    reg_rd = 1; reg_addr = a;
    tick(0, '0, 0);
    @(negedge clk);
    q = reg_rdata;
    reg_rd = 0;
    if (a == 4'd4) rp_m = (rp_m + 1) % DEPTH;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] q;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state and constants
    rd(4'd0, q); chk("R1 ident", q, IDV);
    rd(4'd1, q); chk("R1 depth", q, DEPTH);
    rd(4'd2, q); chk("R1 width", q, 32);
    rd(4'd3, q); chk("R1 status", q, 32'd8);
    rd(4'd8, q); chk("R1 control", q, 0);
    rd(4'd6, q); chk("R1 wptr", q, 0);
    rd(4'd7, q); chk("R1 tcount", q, 0);

    // R2 R6 R7 R8 short capture, no trigger
    wr(4'd7, 32'd100);
    wr(4'd8, 32'd1);
    step(1, 32'hA000_0000, 0);
    rd(4'd3, q); chk("R6 busy pipeline", q[3], 1'b0);
    for (int i = 1; i < 10; i++) step(1, 32'hA000_0000 + i, 0);
    idle(3);
    rd(4'd3, q); chk("R6 drained", q, status_m(1));
    rd(4'd6, q); chk("R2 wptr", q, 10);
    rd(4'd7, q); chk("R8 tcount readback", q, 100);
    wr(4'd5, 0);
    rd(4'd4, q); chk("R7 frame0", q, mem_m[0]);
    rd(4'd4, q); chk("R7 frame1 consecutive", q, 32'hA000_0001);
    rd(4'd5, q); chk("R7 rptr advanced", q, 2);
    wr(4'd5, 7);
    rd(4'd4, q); chk("R8 rptr jump", q, 32'hA000_0007);

    // R9 stop and demux flag
    wr(4'd8, 32'd3);
    rd(4'd8, q); chk("R9 control readback", q, 3);
    wr(4'd8, 32'd2);
    step(1, 32'hDEAD_0000, 0); idle(3);
    rd(4'd6, q); chk("R9 stopped wptr", q, 10);

    // R4 trigger ignored while disabled
    step(0, '0, 1); idle(1);
    rd(4'd3, q); chk("R4 no trigger when disabled", q[1], 1'b0);

    // random capture with wrap and countdown: R2 R3 R5
    wr(4'd6, 0);
    wr(4'd7, 32'd20);
    wr(4'd8, 32'd1);
    for (int i = 0; i < 150; i++)
      step(($urandom % 4) != 0, $urandom, i == 90);
    idle(4);
    rd(4'd3, q); chk("R5 status after countdown", q, 32'hF);
    chk("R5 model consistency", status_m(1), 32'hF);
    rd(4'd8, q); chk("R5 control cleared", q, 0);
    rd(4'd6, q); chk("R3 wptr after wrap", q, wp_m);
    wr(4'd5, wp_m);
    for (int k = 0; k < DEPTH; k++) begin
      rd(4'd4, q);
      chk("R2 ring contents", q, mem_m[(wp_m + k) % DEPTH]);
    end

    // R5 zero countdown
    wr(4'd6, 0);
    rd(4'd3, q); chk("R3 cleared by wptr write", q[0], 1'b0);
    wr(4'd7, 0);
    wr(4'd8, 32'd1);
    step(1, 32'h1111_1111, 0);
    step(1, 32'h2222_2222, 1);
    step(1, 32'h3333_3333, 0);
    step(1, 32'h4444_4444, 0);
    idle(3);
    rd(4'd6, q); chk("R5 zero count wptr", q, 2);
    rd(4'd3, q); chk("R5 zero count status", q, 32'hE);
    wr(4'd5, 1);
    rd(4'd4, q); chk("R5 trigger word stored", q, 32'h2222_2222);

    // R4 control enable clears status; R3 boundary wrap
    wr(4'd6, DEPTH - 1);
    wr(4'd7, 32'd50);
    wr(4'd8, 32'd1);
    rd(4'd3, q); chk("R4 status cleared", q, 32'h8);
    step(1, 32'h5A5A_5A5A, 0); idle(3);
    rd(4'd6, q); chk("R3 wptr wraps to 0", q, 0);
    rd(4'd3, q); chk("R3 wrap flag", q[0], 1'b1);
    wr(4'd5, DEPTH - 1);
    rd(4'd4, q); chk("R2 last slot", q, 32'h5A5A_5A5A);
    rd(4'd5, q); chk("R7 rptr wraps", q, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule